// File: doc/BRIEF.md
# Out-of-Order Micro-op Scheduler

This block is the waiting room between allocation and the execution units of an out-of-order core. Each entry holds one micro-op that has been allocated but not yet sent to execution. The entry keeps its source operand tags with a ready bit for each, its destination tag, the execution port picked for it at allocation, and its program age. The front end writes a micro-op in the same cycle it takes a reorder-buffer slot. When no entry is free, `alloc_ready` drops and the front end has to hold.

Execution units broadcast result tags on the wake lanes, and every waiting source that carries a matching tag becomes ready. In each cycle, every port whose `port_free` is high receives the oldest entry that targets it and has all its sources ready. That entry is released at the next clock edge. Age is a wrapping sequence number with one bit more than the in-flight window, so "older" is decided modulo the sequence space. A flush drops every entry younger than a given age, or every entry at once. Operand values, renaming and the execution units sit outside this block.

Top module: `rs_sched`

## Requirements
- R1: After reset, no port shows a valid issue and `alloc_ready` is high.
- R2: An entry is never issued while any of its sources is not ready. Bit s of `alloc_src_rdy` gives the initial state of source s, and 1 means ready.
- R3: A tag broadcast on any wake lane with its `wake_valid` bit set marks every matching waiting source ready at the next edge. The woken entry can issue at the earliest in the cycle after the broadcast.
- R4: A source written at allocation whose tag matches a broadcast in that same cycle is stored as ready.
- R5: Among the ready entries that target a port, the one with the oldest age is issued first. Age a is older than age b when bit 4 of (a − b) mod 32 is 1, so age 30 is older than age 2.
- R6: A port whose `port_free` bit is low issues nothing, and its entries stay held.
- R7: An entry is issued only on the port number given in `alloc_port`, and each port picks independently, so both ports may issue in one cycle.
- R8: An issued entry is released at the next edge and is never issued again.
- R9: With all 8 entries occupied, `alloc_ready` is low and an allocation attempt is dropped. Freeing entries raises `alloc_ready` again.
- R10: A flush with `flush_all` low removes every entry strictly younger than `flush_age`. Entries of equal or older age are kept.
- R11: A flush with `flush_all` high removes every entry.
- R12: An allocation presented in a flush cycle is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| alloc_valid | input | 1 | Allocation request |
| alloc_ready | output | 1 | At least one entry is free |
| alloc_src_tag | input | NSRC×TAG_W (12) | Source tags, source s in slice s |
| alloc_src_rdy | input | NSRC (2) | Source already ready at allocation |
| alloc_dst_tag | input | TAG_W (6) | Destination tag |
| alloc_port | input | PORT_W (1) | Target execution port |
| alloc_age | input | AGE_W (5) | Program age, wrapping |
| wake_valid | input | NWAKE (2) | Broadcast lane valid |
| wake_tag | input | NWAKE×TAG_W (12) | Broadcast result tags |
| port_free | input | NPORTS (2) | Port can accept a micro-op this cycle |
| issue_valid | output | NPORTS (2) | Micro-op sent to port |
| issue_dst_tag | output | NPORTS×TAG_W (12) | Destination tag of the issued micro-op |
| issue_age | output | NPORTS×AGE_W (10) | Age of the issued micro-op |
| flush_valid | input | 1 | Flush request |
| flush_all | input | 1 | Flush every entry |
| flush_age | input | AGE_W (5) | Flush boundary age |

## Verification
The bench checks oldest-first selection across the age wrap: a design that compared ages as plain unsigned numbers would send age 2 ahead of age 30. It checks that a same-cycle wake followed by issue waits one cycle, and that an allocation bypass is caught. A design that missed the bypass would leave the entry stuck forever. It fills the scheduler to capacity and then offers a ninth micro-op. A design that overwrote an entry, or accepted the extra micro-op, would show a wrong order or an extra issue while draining. For the flush, it puts an older micro-op on the allocation inputs in the flush cycle, so a design that accepted it would issue it ahead of the survivors. It also places an entry exactly at the flush age, so an off-by-one compare would lose that entry.

// File: rtl/rs_sched_pkg.sv
`timescale 1ns/1ps
package rs_sched_pkg;
    localparam int TAG_W = 6;
    localparam int SEQ_W = 4;
    localparam int AGE_W = SEQ_W + 1;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [AGE_W-1:0] age_t;

    // a precedes b in program order (modulo the sequence space)
    function automatic logic age_older(input age_t a, input age_t b);
        age_t diff;
        diff = a - b;
        return diff[AGE_W-1];
    endfunction

    // a follows b strictly
    function automatic logic age_younger(input age_t a, input age_t b);
        age_t diff;
        diff = a - b;
        return !diff[AGE_W-1] && (diff != '0);
    endfunction
endpackage

// File: rtl/rs_wake_match.sv
`timescale 1ns/1ps
module rs_wake_match
    import rs_sched_pkg::*;
#(
    parameter int NSRC  = 2,
    parameter int NWAKE = 2
) (
    input  logic [NSRC-1:0][TAG_W-1:0]  src_tag,
    input  logic [NWAKE-1:0]            wake_valid,
    input  logic [NWAKE-1:0][TAG_W-1:0] wake_tag,
    output logic [NSRC-1:0]             hit
);
    always_comb begin
        hit = '0;
        for (int s = 0; s < NSRC; s++) begin
            for (int w = 0; w < NWAKE; w++) begin
                if (wake_valid[w] && (wake_tag[w] == src_tag[s])) begin
                    hit[s] = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/rs_oldest_pick.sv
`timescale 1ns/1ps
module rs_oldest_pick
    import rs_sched_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0]            cand,
    input  logic [ENTRIES-1:0][AGE_W-1:0] age,
    output logic                          found,
    output logic [IDX_W-1:0]              idx
);
    logic             hit;
    logic [IDX_W-1:0] best_idx;
    age_t             best_age;

    always_comb begin
        hit      = 1'b0;
        best_idx = '0;
        best_age = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (cand[i] && (!hit || age_older(age[i], best_age))) begin
                hit      = 1'b1;
                best_idx = IDX_W'(i);
                best_age = age[i];
            end
        end
        found = hit;
        idx   = best_idx;
    end
endmodule

// File: rtl/rs_free_slot.sv
`timescale 1ns/1ps
module rs_free_slot #(
    parameter int ENTRIES = 8,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic [ENTRIES-1:0] busy,
    output logic               any_free,
    output logic [IDX_W-1:0]   slot
);
    always_comb begin
        any_free = 1'b0;
        slot     = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                any_free = 1'b1;
                slot     = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/rs_sched.sv
`timescale 1ns/1ps
module rs_sched
    import rs_sched_pkg::*;
#(
    parameter int ENTRIES = 8,
    parameter int NPORTS  = 2,
    parameter int NSRC    = 2,
    parameter int NWAKE   = 2,
    localparam int PORT_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         alloc_valid,
    output logic                         alloc_ready,
    input  logic [NSRC-1:0][TAG_W-1:0]   alloc_src_tag,
    input  logic [NSRC-1:0]              alloc_src_rdy,
    input  logic [TAG_W-1:0]             alloc_dst_tag,
    input  logic [PORT_W-1:0]            alloc_port,
    input  logic [AGE_W-1:0]             alloc_age,
    input  logic [NWAKE-1:0]             wake_valid,
    input  logic [NWAKE-1:0][TAG_W-1:0]  wake_tag,
    input  logic [NPORTS-1:0]            port_free,
    output logic [NPORTS-1:0]            issue_valid,
    output logic [NPORTS-1:0][TAG_W-1:0] issue_dst_tag,
    output logic [NPORTS-1:0][AGE_W-1:0] issue_age,
    input  logic                         flush_valid,
    input  logic                         flush_all,
    input  logic [AGE_W-1:0]             flush_age
);
    typedef struct packed {
        logic                       valid;
        logic [NSRC-1:0]            rdy;
        logic [NSRC-1:0][TAG_W-1:0] src;
        logic [TAG_W-1:0]           dst;
        logic [PORT_W-1:0]          port;
        logic [AGE_W-1:0]           age;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
    } state_t;

    state_t st_d, st_q;

    logic [ENTRIES-1:0][NSRC-1:0]   ent_hit;
    logic [NSRC-1:0]                alloc_hit;
    logic [ENTRIES-1:0]             busy;
    logic [ENTRIES-1:0][AGE_W-1:0]  ent_age;
    logic [NPORTS-1:0][ENTRIES-1:0] cand;
    logic [NPORTS-1:0]              pick_found;
    logic [NPORTS-1:0][IDX_W-1:0]   pick_idx;
    logic [ENTRIES-1:0]             issued;
    logic [IDX_W-1:0]               free_idx;
    logic                           any_free;

    // per-entry wakeup compare
    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        rs_wake_match #(.NSRC(NSRC), .NWAKE(NWAKE)) u_wm (
            .src_tag    (st_q.ent[e].src),
            .wake_valid (wake_valid),
            .wake_tag   (wake_tag),
            .hit        (ent_hit[e])
        );
    end

    // same-cycle broadcast seen by a micro-op being written
    rs_wake_match #(.NSRC(NSRC), .NWAKE(NWAKE)) u_wm_alloc (
        .src_tag    (alloc_src_tag),
        .wake_valid (wake_valid),
        .wake_tag   (wake_tag),
        .hit        (alloc_hit)
    );

    // candidate vectors come only from registered ready bits
    always_comb begin
        for (int e = 0; e < ENTRIES; e++) begin
            busy[e]    = st_q.ent[e].valid;
            ent_age[e] = st_q.ent[e].age;
        end
        for (int p = 0; p < NPORTS; p++) begin
            for (int e = 0; e < ENTRIES; e++) begin
                cand[p][e] = st_q.ent[e].valid && (&st_q.ent[e].rdy)
                             && (st_q.ent[e].port == PORT_W'(p));
            end
        end
    end

    for (genvar p = 0; p < NPORTS; p++) begin : g_port
        rs_oldest_pick #(.ENTRIES(ENTRIES)) u_pick (
            .cand  (cand[p]),
            .age   (ent_age),
            .found (pick_found[p]),
            .idx   (pick_idx[p])
        );
    end

    rs_free_slot #(.ENTRIES(ENTRIES)) u_free (
        .busy     (busy),
        .any_free (any_free),
        .slot     (free_idx)
    );

    assign alloc_ready = any_free;

    always_comb begin
        issued = '0;
        for (int p = 0; p < NPORTS; p++) begin
            issue_valid[p]   = port_free[p] && pick_found[p];
            issue_dst_tag[p] = st_q.ent[pick_idx[p]].dst;
            issue_age[p]     = st_q.ent[pick_idx[p]].age;
            if (issue_valid[p]) begin
                issued[pick_idx[p]] = 1'b1;
            end
        end
    end

    // next-state
    always_comb begin
        st_d = st_q;
        for (int e = 0; e < ENTRIES; e++) begin
            st_d.ent[e].rdy = st_q.ent[e].rdy | ent_hit[e];
            if (issued[e]) begin
                st_d.ent[e].valid = 1'b0;
            end
        end
        if (alloc_valid && any_free && !flush_valid) begin
            st_d.ent[free_idx].valid = 1'b1;
            st_d.ent[free_idx].rdy   = alloc_src_rdy | alloc_hit;
            st_d.ent[free_idx].src   = alloc_src_tag;
            st_d.ent[free_idx].dst   = alloc_dst_tag;
            st_d.ent[free_idx].port  = alloc_port;
            st_d.ent[free_idx].age   = alloc_age;
        end
        if (flush_valid) begin
            for (int e = 0; e < ENTRIES; e++) begin
                if (flush_all || age_younger(st_q.ent[e].age, flush_age)) begin
                    st_d.ent[e].valid = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/rs_sched_chk.sv
`timescale 1ns/1ps
module rs_sched_chk
    import rs_sched_pkg::*;
#(
    parameter int NPORTS = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         alloc_valid,
    input logic                         alloc_ready,
    input logic [NPORTS-1:0]            port_free,
    input logic [NPORTS-1:0]            issue_valid,
    input logic [NPORTS-1:0][TAG_W-1:0] issue_dst_tag,
    input logic [NPORTS-1:0][AGE_W-1:0] issue_age,
    input logic                         flush_valid,
    input logic                         flush_all,
    input logic [AGE_W-1:0]             flush_age
);
    for (genvar p = 0; p < NPORTS; p++) begin : g_p
        AST_ISSUE_NEEDS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
            issue_valid[p] |-> port_free[p]); // R6

        AST_NO_REISSUE: assert property (@(posedge clk) disable iff (!rst_n)
            (issue_valid[p] && !alloc_valid) |=>
            !(issue_valid[p] && (issue_dst_tag[p] == $past(issue_dst_tag[p]))
              && (issue_age[p] == $past(issue_age[p])))); // R8

        AST_FLUSH_AGE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
            (flush_valid && !flush_all) |=>
            !(issue_valid[p] && age_younger(issue_age[p], $past(flush_age)))); // R10
    end

    AST_FLUSH_ALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_all) |=> (issue_valid == '0)); // R11

    AST_FLUSH_ALL_FREES: assert property (@(posedge clk) disable iff (!rst_n)
        (flush_valid && flush_all) |=> alloc_ready); // R9
endmodule

bind rs_sched rs_sched_chk #(.NPORTS(NPORTS)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .alloc_valid   (alloc_valid),
    .alloc_ready   (alloc_ready),
    .port_free     (port_free),
    .issue_valid   (issue_valid),
    .issue_dst_tag (issue_dst_tag),
    .issue_age     (issue_age),
    .flush_valid   (flush_valid),
    .flush_all     (flush_all),
    .flush_age     (flush_age)
);

// File: tb/rs_sched_test.sv
`timescale 1ns/1ps
module rs_sched_test;
    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             alloc_valid = 1'b0;
    logic             alloc_ready;
    logic [1:0][5:0]  alloc_src_tag = '0;
    logic [1:0]       alloc_src_rdy = '0;
    logic [5:0]       alloc_dst_tag = '0;
    logic [0:0]       alloc_port = '0;
    logic [4:0]       alloc_age = '0;
    logic [1:0]       wake_valid = '0;
    logic [1:0][5:0]  wake_tag = '0;
    logic [1:0]       port_free = '0;
    logic [1:0]       issue_valid;
    logic [1:0][5:0]  issue_dst_tag;
    logic [1:0][4:0]  issue_age;
    logic             flush_valid = 1'b0;
    logic             flush_all = 1'b0;
    logic [4:0]       flush_age = '0;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    rs_sched #(.ENTRIES(8), .NPORTS(2), .NSRC(2), .NWAKE(2)) uut (
        .clk(clk), .rst_n(rst_n),
        .alloc_valid(alloc_valid), .alloc_ready(alloc_ready),
        .alloc_src_tag(alloc_src_tag), .alloc_src_rdy(alloc_src_rdy),
        .alloc_dst_tag(alloc_dst_tag), .alloc_port(alloc_port), .alloc_age(alloc_age),
        .wake_valid(wake_valid), .wake_tag(wake_tag),
        .port_free(port_free),
        .issue_valid(issue_valid), .issue_dst_tag(issue_dst_tag), .issue_age(issue_age),
        .flush_valid(flush_valid), .flush_all(flush_all), .flush_age(flush_age)
    );

    typedef struct packed {
        logic       av;
        logic [5:0] s0;
        logic [5:0] s1;
        logic [1:0] srdy;
        logic [5:0] dst;
        logic       pt;
        logic [4:0] age;
        logic       wv;
        logic [5:0] wt;
        logic [1:0] pf;
        logic [1:0] eiv;
        logic [5:0] ed0;
        logic [5:0] ed1;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VEC [0:NV-1] = '{
        '{1'b1, 6'd1, 6'd2, 2'b00, 6'd10, 1'b0, 5'd0,  1'b0, 6'd0, 2'b11, 2'b00, 6'd0,  6'd0},
        '{1'b1, 6'd3, 6'd4, 2'b11, 6'd11, 1'b0, 5'd1,  1'b0, 6'd0, 2'b11, 2'b00, 6'd0,  6'd0},
        '{1'b0, 6'd0, 6'd0, 2'b00, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0, 2'b00, 2'b00, 6'd0,  6'd0},
        '{1'b0, 6'd0, 6'd0, 2'b00, 6'd0,  1'b0, 5'd0,  1'b1, 6'd1, 2'b11, 2'b01, 6'd11, 6'd0},
        '{1'b0, 6'd0, 6'd0, 2'b00, 6'd0,  1'b0, 5'd0,  1'b1, 6'd2, 2'b11, 2'b00, 6'd0,  6'd0},
        '{1'b0, 6'd0, 6'd0, 2'b00, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0, 2'b11, 2'b01, 6'd10, 6'd0},
        '{1'b1, 6'd5, 6'd6, 2'b00, 6'd12, 1'b1, 5'd2,  1'b1, 6'd5, 2'b11, 2'b00, 6'd0,  6'd0},
        '{1'b0, 6'd0, 6'd0, 2'b00, 6'd0,  1'b0, 5'd0,  1'b1, 6'd6, 2'b11, 2'b00, 6'd0,  6'd0},
        '{1'b0, 6'd0, 6'd0, 2'b00, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0, 2'b11, 2'b10, 6'd0,  6'd12},
        '{1'b1, 6'd7, 6'd8, 2'b11, 6'd20, 1'b0, 5'd30, 1'b0, 6'd0, 2'b00, 2'b00, 6'd0,  6'd0},
        '{1'b1, 6'd7, 6'd8, 2'b11, 6'd21, 1'b0, 5'd2,  1'b0, 6'd0, 2'b00, 2'b00, 6'd0,  6'd0},
        '{1'b1, 6'd7, 6'd8, 2'b11, 6'd22, 1'b1, 5'd31, 1'b0, 6'd0, 2'b00, 2'b00, 6'd0,  6'd0},
        '{1'b0, 6'd0, 6'd0, 2'b00, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0, 2'b11, 2'b11, 6'd20, 6'd22},
        '{1'b0, 6'd0, 6'd0, 2'b00, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0, 2'b01, 2'b01, 6'd21, 6'd0},
        '{1'b0, 6'd0, 6'd0, 2'b00, 6'd0,  1'b0, 5'd0,  1'b0, 6'd0, 2'b11, 2'b00, 6'd0,  6'd0}
    };

    function automatic string vec_req(input int i);
        case (i)
            0, 1, 4:  return "R2";
            2:        return "R6";
            3, 7:     return "R3";
            5:        return "R3";
            6, 8:     return "R4";
            12:       return "R5";
            13:       return "R7";
            default:  return "R8";
        endcase
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic next_cycle();
        @(negedge clk);
        alloc_valid   = 1'b0;
        alloc_src_rdy = '0;
        wake_valid    = '0;
        flush_valid   = 1'b0;
        flush_all     = 1'b0;
        port_free     = '0;
    endtask

    task automatic put(input int dst, input int pt, input int age, input logic [1:0] rdy,
                       input int t0, input int t1);
        alloc_valid      = 1'b1;
        alloc_dst_tag    = 6'(dst);
        alloc_port       = 1'(pt);
        alloc_age        = 5'(age);
        alloc_src_rdy    = rdy;
        alloc_src_tag[0] = 6'(t0);
        alloc_src_tag[1] = 6'(t1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
            $finish;
        end
    endtask

    initial begin
        #(5.0 * 100000);
        nchk++;
        nerr++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        next_cycle();
        port_free = 2'b11;
        #1;
        check("R1", "issue_valid after reset", int'(issue_valid), 0);
        check("R1", "alloc_ready after reset", int'(alloc_ready), 1);

        // table walk
        for (int i = 0; i < NV; i++) begin
            next_cycle();
            alloc_valid      = VEC[i].av;
            alloc_src_tag[0] = VEC[i].s0;
            alloc_src_tag[1] = VEC[i].s1;
            alloc_src_rdy    = VEC[i].srdy;
            alloc_dst_tag    = VEC[i].dst;
            alloc_port       = VEC[i].pt;
            alloc_age        = VEC[i].age;
            wake_valid       = {1'b0, VEC[i].wv};
            wake_tag[0]      = VEC[i].wt;
            port_free        = VEC[i].pf;
            #1;
            check(vec_req(i), "vector issue_valid", int'(issue_valid), int'(VEC[i].eiv));
            if (VEC[i].eiv[0]) check(vec_req(i), "vector port0 dst", int'(issue_dst_tag[0]), int'(VEC[i].ed0));
            if (VEC[i].eiv[1]) check(vec_req(i), "vector port1 dst", int'(issue_dst_tag[1]), int'(VEC[i].ed1));
        end

        // R2/R3 with wake lane 1
        next_cycle();
        put(48, 0, 13, 2'b10, 20, 21);
        next_cycle();
        port_free = 2'b01; wake_valid = 2'b10; wake_tag[1] = 6'd21;
        #1; check("R2", "blocked by unready src0", int'(issue_valid), 0);
        next_cycle();
        port_free = 2'b01; wake_valid = 2'b10; wake_tag[1] = 6'd20;
        #1; check("R3", "no issue in wake cycle", int'(issue_valid), 0);
        next_cycle();
        port_free = 2'b01;
        #1; check("R3", "issue after wake", int'(issue_valid), 1);
        check("R3", "woken dst", int'(issue_dst_tag[0]), 48);

        // R9: fill to capacity, then drain in age order
        for (int k = 0; k < 8; k++) begin
            next_cycle();
            #1; check("R9", "ready before fill", int'(alloc_ready), 1);
            put(30 + k, 0, k, 2'b11, 0, 0);
        end
        next_cycle();
        #1; check("R9", "ready when full", int'(alloc_ready), 0);
        put(50, 0, 8, 2'b11, 0, 0);
        for (int k = 0; k < 8; k++) begin
            next_cycle();
            port_free = 2'b01;
            #1; check("R5", "drain order", int'(issue_dst_tag[0]), 30 + k);
        end
        next_cycle();
        port_free = 2'b01;
        #1; check("R9", "dropped alloc absent", int'(issue_valid), 0);
        check("R9", "ready after drain", int'(alloc_ready), 1);

        // R10/R12: age flush with an older alloc in the same cycle
        for (int k = 0; k < 4; k++) begin
            next_cycle();
            put(40 + k, 0, 4 + k, 2'b11, 0, 0);
        end
        next_cycle();
        flush_valid = 1'b1; flush_age = 5'd5;
        put(44, 0, 3, 2'b11, 0, 0);
        next_cycle();
        port_free = 2'b01;
        #1; check("R12", "flush-cycle alloc dropped", int'(issue_dst_tag[0]), 40);
        next_cycle();
        port_free = 2'b01;
        #1; check("R10", "equal age kept", int'(issue_valid), 1);
        check("R10", "equal age dst", int'(issue_dst_tag[0]), 41);
        next_cycle();
        port_free = 2'b01;
        #1; check("R10", "younger removed", int'(issue_valid), 0);

        // R11: flush all
        next_cycle(); put(45, 0, 10, 2'b11, 0, 0);
        next_cycle(); put(46, 1, 11, 2'b11, 0, 0);
        next_cycle();
        flush_valid = 1'b1; flush_all = 1'b1; flush_age = 5'd31;
        next_cycle();
        port_free = 2'b11;
        #1; check("R11", "all removed", int'(issue_valid), 0);

        // R7: port steering
        next_cycle(); put(47, 1, 12, 2'b11, 0, 0);
        next_cycle();
        port_free = 2'b01;
        #1; check("R7", "wrong port idle", int'(issue_valid), 0);
        next_cycle();
        port_free = 2'b10;
        #1; check("R7", "own port issues", int'(issue_valid), 2);
        check("R7", "own port dst", int'(issue_dst_tag[1]), 47);

        // R1: mid-run reset discards held entry
        next_cycle(); put(9, 0, 14, 2'b11, 0, 0);
        next_cycle(); rst_n = 1'b0;
        next_cycle(); rst_n = 1'b1;
        next_cycle();
        port_free = 2'b11;
        #1; check("R1", "empty after reset", int'(issue_valid), 0);

        finish_run();
    end
endmodule